// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block is the trap sequencing logic of a 32-bit system coprocessor. It owns four registers: status, cause, exception return address (EPC) and faulting address. When a synchronous exception request arrives, or when an enabled external interrupt is pending, it performs a trap entry in a single clock edge. On that edge it:

- picks the handler address;
- pushes the three-level stack of (interrupt-enable, kernel/user) pairs held in the low status bits;
- records the cause code and whether the trap hit a branch delay slot;
- saves the address to return to.

A return-from-exception strobe pops that stack back. Simple move-to and move-from ports let software read and write the registers by number.

The fetch unit watches `redirect` and `redirectPc`. When `redirect` is high, it discards any pending delay-slot branch and fetches next from `redirectPc`. In the first cycle after reset, `redirect` also delivers the boot address.

Top module: `trap_entry_unit`

## Requirements
- R1: In the first cycle after reset is released, `redirect` is 1 and `redirectPc` is 0xBFC00000. An exception request in that cycle is ignored. All four registers reset to 0.
- R2: When a trap entry occurs, `redirect` is 1 in that cycle. `redirectPc` is 0xBFC00180 if status bit 22 is 1, and 0x80000080 otherwise.
- R3: On entry, status bits 5:0 become the old bits 3:0 followed by two zero bits. Status bits 31:6 are unchanged.
- R4: On entry, cause bits 7:0 become {0, code[4:0], 00}. Cause bits 9:8 are kept.
- R5: On entry, cause bit 31 takes the value of `inDelaySlot`. EPC becomes `curPc`, or `curPc` − 4 when `inDelaySlot` is 1.
- R6: The faulting-address register (number 8) loads `curPc` only on a synchronous entry with code 4 or 5. On any other entry it is kept.
- R7: A return strobe with no entry in the same cycle copies status bits 5:2 into bits 3:0. Every other status bit is left as it was.
- R8: Every cycle, cause bit 10 loads the OR of (`irqStatus` AND `irqMask`). It is therefore visible one cycle later.
- R9: A pending interrupt causes an entry only when status bit 0 and status bit 10 are both 1. Such an entry records code 0.
- R10: If an enabled interrupt and an exception request arrive in the same cycle, exactly one entry happens and it is the interrupt entry (code 0).
- R11: Register numbers are 12 for status, 13 for cause, 14 for EPC and 8 for the faulting address. Other numbers read as 0. Moves write status and EPC in full, write only bits 9:8 of cause, and never write the faulting-address register.
- R12: In a cycle with an entry, a move-to write and a return strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPc | input | 32 | Address of the instruction being trapped |
| inDelaySlot | input | 1 | That instruction sits in a branch delay slot |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 5 | Code of the synchronous exception |
| irqStatus | input | IRQ_W | Raw interrupt status lines |
| irqMask | input | IRQ_W | Interrupt mask lines |
| rfeReq | input | 1 | Return-from-exception strobe |
| mtcEn | input | 1 | Move-to register write strobe |
| regAddr | input | 5 | Register number for move-to and move-from |
| wrData | input | 32 | Move-to write data |
| rdData | output | 32 | Move-from read data (combinational) |
| redirect | output | 1 | Fetch must restart at `redirectPc` and drop any pending branch |
| redirectPc | output | 32 | Boot or handler address |

## Verification
The bench pushes the mode stack from a known pattern and checks the 6-bit truncation. A design that kept bits 7:6, or that shifted by one, shows wrong status bits. It traps in a delay slot with the faulting-address code set, then traps out of one with a different code. This exposes an EPC that is not rewound, a stale cause bit 31, and a faulting-address register that loads on every entry.

It lowers the interrupt enable and then raises an interrupt together with a synchronous request. A design that ignores the enable gate, or lets the synchronous code win, records the wrong code or redirects when it should not. It also collides a register write and a return strobe with an entry, and fills cause with ones through a move. A design that lets the collided write through, or lets software touch the read-only cause fields, ends with visible extra bits.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int CW = 5;

  localparam logic [AW-1:0] ADDR_BAD   = 5'd8;
  localparam logic [AW-1:0] ADDR_STAT  = 5'd12;
  localparam logic [AW-1:0] ADDR_CAUSE = 5'd13;
  localparam logic [AW-1:0] ADDR_EPC   = 5'd14;

  localparam logic [DW-1:0] BOOT_VEC = 32'hBFC0_0000;
  localparam logic [DW-1:0] VEC_ROM  = 32'hBFC0_0180;
  localparam logic [DW-1:0] VEC_RAM  = 32'h8000_0080;

  localparam logic [CW-1:0] CODE_IRQ  = 5'd0;
  localparam logic [CW-1:0] CODE_ADRL = 5'd4;
  localparam logic [CW-1:0] CODE_ADRS = 5'd5;

  // status bit positions the control logic depends on
  localparam int ST_IEC  = 0;
  localparam int ST_IMSK = 10;
  localparam int ST_BEV  = 22;
  localparam int CA_PEND = 10;
  localparam int CA_BD   = 31;

  typedef struct packed {
    logic          enter;
    logic          recordBad;
    logic [CW-1:0] code;
    logic          popStack;
    logic          wrStatus;
    logic          wrCause;
    logic          wrEpc;
  } strobes_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  logic [CW-1:0]    excCode,
  input  logic [IRQ_W-1:0] irqStatus,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic             statusIe,
  input  logic             statusIm,
  input  logic             rfeReq,
  input  logic             mtcEn,
  input  logic [AW-1:0]    regAddr,
  output strobes_t         strb,
  output logic             bootCycle,
  output logic             irqPend
);
  logic bootQ;
  logic irqTake;
  logic syncTake;
  logic mtcLive;

  always_ff @(posedge clk) begin
    if (!rstN) bootQ <= 1'b1;
    else       bootQ <= 1'b0;
  end

  assign bootCycle = bootQ;
  assign irqPend   = |(irqStatus & irqMask);
  assign irqTake   = irqPend && statusIe && statusIm && !bootQ;
  assign syncTake  = excReq && !bootQ;

  always_comb begin
    strb           = '0;
    strb.enter     = irqTake || syncTake;
    strb.code      = irqTake ? CODE_IRQ : excCode;
    strb.recordBad = syncTake && !irqTake &&
                     ((excCode == CODE_ADRL) || (excCode == CODE_ADRS));
    strb.popStack  = rfeReq && !strb.enter;
    mtcLive        = mtcEn && !strb.enter;
    strb.wrStatus  = mtcLive && (regAddr == ADDR_STAT);
    strb.wrCause   = mtcLive && (regAddr == ADDR_CAUSE);
    strb.wrEpc     = mtcLive && (regAddr == ADDR_EPC);
  end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic          bootCycle,
  input  logic          irqPend,
  input  logic [DW-1:0] curPc,
  input  logic          inDelaySlot,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] redirectPc,
  output logic [DW-1:0] statusQ,
  output logic [DW-1:0] causeQ,
  output logic [DW-1:0] epcQ,
  output logic [DW-1:0] badQ
);
  logic [DW-1:0] savedPc;

  assign savedPc = inDelaySlot ? (curPc - 32'd4) : curPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      causeQ  <= '0;
      epcQ    <= '0;
      badQ    <= '0;
    end else begin
      causeQ[CA_PEND] <= irqPend;
      if (strb.enter) begin
        statusQ[5:0]   <= {statusQ[3:0], 2'b00};
        causeQ[CA_BD]  <= inDelaySlot;
        causeQ[7:0]    <= {1'b0, strb.code, 2'b00};
        epcQ           <= savedPc;
        if (strb.recordBad) badQ <= curPc;
      end else begin
        if (strb.popStack) statusQ[3:0] <= statusQ[5:2];
        if (strb.wrStatus) statusQ      <= wrData;
        if (strb.wrCause)  causeQ[9:8]  <= wrData[9:8];
        if (strb.wrEpc)    epcQ         <= wrData;
      end
    end
  end

  always_comb begin
    if (bootCycle)             redirectPc = BOOT_VEC;
    else if (statusQ[ST_BEV])  redirectPc = VEC_ROM;
    else                       redirectPc = VEC_RAM;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STAT:  rdData = statusQ;
      ADDR_CAUSE: rdData = causeQ;
      ADDR_EPC:   rdData = epcQ;
      ADDR_BAD:   rdData = badQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      curPc,
  input  logic             inDelaySlot,
  input  logic             excReq,
  input  logic [4:0]       excCode,
  input  logic [IRQ_W-1:0] irqStatus,
  input  logic [IRQ_W-1:0] irqMask,
  input  logic             rfeReq,
  input  logic             mtcEn,
  input  logic [4:0]       regAddr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             redirect,
  output logic [31:0]      redirectPc
);
  strobes_t      strb;
  logic          bootCycle;
  logic          irqPend;
  logic          enterNow;
  logic [DW-1:0] statusQ;
  logic [DW-1:0] causeQ;
  logic [DW-1:0] epcQ;
  logic [DW-1:0] badQ;

  trap_ctrl #(.IRQ_W(IRQ_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .excReq    (excReq),
    .excCode   (excCode),
    .irqStatus (irqStatus),
    .irqMask   (irqMask),
    .statusIe  (statusQ[ST_IEC]),
    .statusIm  (statusQ[ST_IMSK]),
    .rfeReq    (rfeReq),
    .mtcEn     (mtcEn),
    .regAddr   (regAddr),
    .strb      (strb),
    .bootCycle (bootCycle),
    .irqPend   (irqPend)
  );

  trap_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .bootCycle   (bootCycle),
    .irqPend     (irqPend),
    .curPc       (curPc),
    .inDelaySlot (inDelaySlot),
    .regAddr     (regAddr),
    .wrData      (wrData),
    .rdData      (rdData),
    .redirectPc  (redirectPc),
    .statusQ     (statusQ),
    .causeQ      (causeQ),
    .epcQ        (epcQ),
    .badQ        (badQ)
  );

  assign enterNow = strb.enter;
  assign redirect = bootCycle || enterNow;
endmodule

// File: rtl/trap_chk.sv
module trap_chk #(
  parameter int IRQ_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             redirect,
  input logic [31:0]      redirectPc,
  input logic [31:0]      curPc,
  input logic             inDelaySlot,
  input logic             excReq,
  input logic [IRQ_W-1:0] irqStatus,
  input logic [IRQ_W-1:0] irqMask,
  input logic             rfeReq,
  input logic             mtcEn,
  input logic [4:0]       regAddr,
  input logic             enterNow,
  input logic [31:0]      statusQ,
  input logic [31:0]      causeQ,
  input logic [31:0]      epcQ
);
  logic seenQ;

  always_ff @(posedge clk) begin
    if (!rstN) seenQ <= 1'b0;
    else       seenQ <= 1'b1;
  end

  AST_BOOT_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    !seenQ |-> (redirect && redirectPc == 32'hBFC0_0000)); // R1

  AST_VECTOR_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && redirect) |->
      (redirectPc == (statusQ[22] ? 32'hBFC0_0180 : 32'h8000_0080))); // R2

  AST_STACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    enterNow |=> (statusQ[5:0] == {$past(statusQ[3:0]), 2'b00})); // R3

  AST_EPC_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    (enterNow && inDelaySlot) |=>
      (epcQ == $past(curPc) - 32'd4 && causeQ[31])); // R5

  AST_RFE_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rfeReq && !enterNow && !(mtcEn && regAddr == 5'd12)) |=>
      (statusQ[3:0] == $past(statusQ[5:2]) &&
       statusQ[31:4] == $past(statusQ[31:4]))); // R7

  AST_PEND_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    seenQ |=> (causeQ[10] == $past(|(irqStatus & irqMask)))); // R8

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && !excReq && !(statusQ[0] && statusQ[10])) |-> !redirect); // R9
endmodule

bind trap_entry_unit trap_chk #(.IRQ_W(IRQ_W)) u_trap_chk (
  .clk         (clk),
  .rstN        (rstN),
  .redirect    (redirect),
  .redirectPc  (redirectPc),
  .curPc       (curPc),
  .inDelaySlot (inDelaySlot),
  .excReq      (excReq),
  .irqStatus   (irqStatus),
  .irqMask     (irqMask),
  .rfeReq      (rfeReq),
  .mtcEn       (mtcEn),
  .regAddr     (regAddr),
  .enterNow    (enterNow),
  .statusQ     (statusQ),
  .causeQ      (causeQ),
  .epcQ        (epcQ)
);

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
  localparam int IRQ_W = 11;

  logic             clk = 1'b0;
  logic             rstN;
  logic [31:0]      curPc;
  logic             inDelaySlot;
  logic             excReq;
  logic [4:0]       excCode;
  logic [IRQ_W-1:0] irqStatus;
  logic [IRQ_W-1:0] irqMask;
  logic             rfeReq;
  logic             mtcEn;
  logic [4:0]       regAddr;
  logic [31:0]      wrData;
  logic [31:0]      rdData;
  logic             redirect;
  logic [31:0]      redirectPc;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  trap_entry_unit #(.IRQ_W(IRQ_W)) i_trap_entry_unit (
    .clk(clk), .rstN(rstN), .curPc(curPc), .inDelaySlot(inDelaySlot),
    .excReq(excReq), .excCode(excCode), .irqStatus(irqStatus),
    .irqMask(irqMask), .rfeReq(rfeReq), .mtcEn(mtcEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .redirect(redirect),
    .redirectPc(redirectPc)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    curPc = 0; inDelaySlot = 0; excReq = 0; excCode = 0;
    irqStatus = 0; irqMask = 0; rfeReq = 0; mtcEn = 0;
    regAddr = 0; wrData = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [31:0] d);
    mtcEn = 1; regAddr = a; wrData = d;
    step();
    mtcEn = 0; wrData = 0;
  endtask

  task automatic raise(input logic [4:0] code, input logic [31:0] pc,
                       input logic ds, input logic [31:0] vec,
                       input string req);
    excReq = 1; excCode = code; curPc = pc; inDelaySlot = ds;
    #1;
    check({req, " redirect"}, {31'd0, redirect}, 32'd1);
    check({req, " vector"}, redirectPc, vec);
    step();
    excReq = 0; excCode = 0; curPc = 0; inDelaySlot = 0;
  endtask

  task automatic t_reset_boot();
    logic [31:0] v;
    rstN = 0; idle();
    repeat (3) @(negedge clk);
    readReg(5'd12, v); check("R1 status reset", v, 32'h0);
    readReg(5'd8,  v); check("R1 bad reset", v, 32'h0);
    excReq = 1; excCode = 5'd8; curPc = 32'h0000_1234;
    rstN = 1;
    #1;
    check("R1 boot redirect", {31'd0, redirect}, 32'd1);
    check("R1 boot vector", redirectPc, 32'hBFC0_0000);
    step();
    idle();
    #1 check("R1 no later redirect", {31'd0, redirect}, 32'd0);
    readReg(5'd14, v); check("R1 request in boot cycle ignored (epc)", v, 32'h0);
    readReg(5'd13, v); check("R1 request in boot cycle ignored (cause)", v, 32'h0);
  endtask

  task automatic t_plain_entry();
    logic [31:0] v;
    writeReg(5'd12, 32'h0000_0415);
    readReg(5'd12, v); check("R11 status writable", v, 32'h0000_0415);
    raise(5'd8, 32'h0000_1000, 1'b0, 32'h8000_0080, "R2");
    readReg(5'd12, v); check("R3 push", v, 32'h0000_0414);
    readReg(5'd13, v); check("R4 code", v, 32'h0000_0020);
    readReg(5'd14, v); check("R5 epc plain", v, 32'h0000_1000);
    readReg(5'd8,  v); check("R6 bad kept for code 8", v, 32'h0);
  endtask

  task automatic t_delay_slot();
    logic [31:0] v;
    writeReg(5'd12, 32'h0040_0003);
    raise(5'd4, 32'h0000_2008, 1'b1, 32'hBFC0_0180, "R2 rom");
    readReg(5'd12, v); check("R3 push truncates", v, 32'h0040_000C);
    readReg(5'd13, v); check("R5 bd flag", v, 32'h8000_0010);
    readReg(5'd14, v); check("R5 epc rewind", v, 32'h0000_2004);
    readReg(5'd8,  v); check("R6 bad code 4", v, 32'h0000_2008);
  endtask

  task automatic t_store_fault();
    logic [31:0] v;
    writeReg(5'd12, 32'h0);
    raise(5'd5, 32'h0000_3000, 1'b0, 32'h8000_0080, "R2 ram");
    readReg(5'd13, v); check("R5 bd cleared", v, 32'h0000_0014);
    readReg(5'd8,  v); check("R6 bad code 5", v, 32'h0000_3000);
  endtask

  task automatic t_return();
    logic [31:0] v;
    writeReg(5'd12, 32'h1234_5638);
    rfeReq = 1;
    step();
    rfeReq = 0;
    readReg(5'd12, v); check("R7 pop", v, 32'h1234_563E);
  endtask

  task automatic t_interrupts();
    logic [31:0] v;
    writeReg(5'd12, 32'h0000_0400);
    irqStatus = 11'h001; irqMask = 11'h001;
    #1 check("R9 gated off", {31'd0, redirect}, 32'd0);
    step();
    readReg(5'd13, v); check("R8 pending mirrored", v, 32'h0000_0414);
    irqMask = 0;
    step();
    readReg(5'd13, v); check("R8 pending drops", v, 32'h0000_0014);
    irqStatus = 0;
    writeReg(5'd12, 32'h0000_0401);
    irqStatus = 11'h004; irqMask = 11'h00C;
    raise(5'd8, 32'h0000_4000, 1'b0, 32'h8000_0080, "R10");
    irqStatus = 0; irqMask = 0;
    readReg(5'd13, v); check("R10 irq wins code 0", v, 32'h0000_0400);
    readReg(5'd12, v); check("R9 irq entry push", v, 32'h0000_0404);
    readReg(5'd14, v); check("R10 single entry epc", v, 32'h0000_4000);
  endtask

  task automatic t_moves();
    logic [31:0] v;
    writeReg(5'd13, 32'hFFFF_FFFF);
    readReg(5'd13, v); check("R11 cause only 9:8", v, 32'h0000_0300);
    writeReg(5'd8, 32'h0000_DEAD);
    readReg(5'd8, v); check("R11 bad read-only", v, 32'h0000_3000);
    writeReg(5'd14, 32'hCAFE_0000);
    readReg(5'd14, v); check("R11 epc writable", v, 32'hCAFE_0000);
    readReg(5'd3, v); check("R11 unmapped reads 0", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    mtcEn = 1; regAddr = 5'd12; wrData = 32'hFFFF_FFFF; rfeReq = 1;
    raise(5'd8, 32'h0000_5000, 1'b0, 32'h8000_0080, "R12");
    mtcEn = 0; rfeReq = 0; wrData = 0;
    readReg(5'd12, v); check("R12 write and pop dropped", v, 32'h0000_0410);
    readReg(5'd14, v); check("R12 epc from entry", v, 32'h0000_5000);
  endtask

  initial begin
    t_reset_boot();
    t_plain_entry();
    t_delay_slot();
    t_store_fault();
    t_return();
    t_interrupts();
    t_moves();
    t_collision();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule